// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Latency

This block carries data words from one clock domain into another, unrelated clock domain. The writer and the reader run on independent clocks. The reader may be the faster side, for example a 150 MHz reader draining a 125 MHz writer. In that case the FIFO keeps going empty and filling again, and reads arrive in bursts with gaps between them.

A build-time parameter sets the shape of the read port. In standard mode a word is returned on the read-clock cycle after it is requested. In fall-through mode the oldest word is already on the output whenever the FIFO holds data, and a read request consumes it. With either mode, a consumer may drive its read request from the registered inverse of the empty flag, provided it samples data with the latency of the chosen mode.

Each side has its own occupancy count, computed from its local pointer and the synchronized pointer from the other side. Because of the synchronizer delay, each count can lag the true fill level. Each side also has a programmable threshold flag. On the read side, a guard output asserts only when the count is above a reserve level. A reader that gates on the guard keeps some words in hand and never drains the FIFO to empty.

Top module: `xclk_fifo`

## Requirements
- R1: While rst_ni is low, and after its release until the first write, the flags read as follows: empty_o=1, full_o=0, almost_empty_o=1, almost_full_o=0, guard_o=0, rd_valid_o=0, overflow_o=0, underflow_o=0, and both counts are 0.
- R2: Words leave the FIFO in the order they were accepted, with none lost or duplicated.
- R3: full_o is 1 exactly when wr_count_o equals DEPTH. A write while full_o=1 is ignored and sets overflow_o, which then stays 1 until reset.
- R4: empty_o is 1 exactly when rd_count_o is 0. A read while empty_o=1 is ignored and sets underflow_o, which then stays 1 until reset.
- R5: With RD_MODE=RD_STD (0), a read accepted at a read-clock edge makes rd_valid_o=1 and puts the word on rd_data_o for the following read-clock cycle. In every other cycle rd_valid_o=0.
- R6: With RD_MODE=RD_FWFT (1), rd_valid_o equals the inverse of empty_o, and rd_data_o shows the oldest stored word. A read consumes that word.
- R7: A word written into an empty FIFO does not clear empty_o until at least the second read-clock rising edge after the write edge. It does clear empty_o within four read-clock cycles.
- R8: Neither count ever exceeds DEPTH. Once both ports have been idle for a few cycles, wr_count_o and rd_count_o both equal the number of stored words.
- R9: almost_full_o is 1 exactly when wr_count_o >= AF_LEVEL (default 12). almost_empty_o is 1 exactly when rd_count_o <= AE_LEVEL (default 2).
- R10: guard_o is 1 exactly when rd_count_o > GUARD_LEVEL (default 5). For example, it is 0 at 5 stored words and 1 at 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously in each domain |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | No free entry |
| almost_full_o | output | 1 | Write count at or above AF_LEVEL |
| wr_count_o | output | $clog2(DEPTH)+1 | Occupancy as seen by the write side |
| overflow_o | output | 1 | Sticky: a write was attempted while full |
| rd_en_i | input | 1 | Read request / consume |
| rd_data_o | output | DATA_W | Read word |
| rd_valid_o | output | 1 | rd_data_o holds a valid word |
| empty_o | output | 1 | No word visible to the read side |
| almost_empty_o | output | 1 | Read count at or below AE_LEVEL |
| guard_o | output | 1 | Read count above GUARD_LEVEL |
| rd_count_o | output | $clog2(DEPTH)+1 | Occupancy as seen by the read side |
| underflow_o | output | 1 | Sticky: a read was attempted while empty |

## Verification
The hardest case to reach from the ports is the exact moment a single word crosses into an idle read domain, where empty_o must still be high after one read edge and low a few edges later. The stimulus reaches it with one forced write placed at a known write edge. The read flags are then sampled after the first read edge and again after four more. The boundaries are reached with forced bursts: writes run past DEPTH to hit full and overflow, reads run past empty to hit underflow, and exact fills of 5 and 6 words sit on either side of the guard level. Long random phases with the read clock faster than the write clock then toggle empty in the intermittent pattern. Both read modes are driven with the same stimulus.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/xclk_fifo_rst_sync.sv
module xclk_fifo_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 2'b00;
    else         q <= {q[0], 1'b1};
  end
  assign rst_no = q[1];
endmodule

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/xclk_fifo_ptr.sv
module xclk_fifo_ptr #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] bin_o,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_d;
  assign bin_d = bin_o + W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo_g2b.sv
module xclk_fifo_g2b #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^(gray_i >> i);
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int       DATA_W      = 8,
  parameter int       DEPTH       = 16,
  parameter int       AF_LEVEL    = 12,
  parameter int       AE_LEVEL    = 2,
  parameter int       GUARD_LEVEL = 5,
  parameter rd_mode_e RD_MODE     = RD_FWFT,
  localparam int      AW          = $clog2(DEPTH),
  localparam int      CW          = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              almost_full_o,
  output logic [CW-1:0]     wr_count_o,
  output logic              overflow_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              empty_o,
  output logic              almost_empty_o,
  output logic              guard_o,
  output logic [CW-1:0]     rd_count_o,
  output logic              underflow_o
);
  localparam bit IS_FWFT = (RD_MODE == RD_FWFT);

  logic wrst_n, rrst_n;
  logic wr_do, rd_do;
  logic [CW-1:0] wbin, wgray, rbin, rgray;
  logic [CW-1:0] wgray_r, rgray_w, wbin_r, rbin_w;
  logic [DATA_W-1:0] mem [DEPTH];

  xclk_fifo_rst_sync u_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n));
  xclk_fifo_rst_sync u_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n));

  assign wr_do = wr_en_i & ~full_o;
  assign rd_do = rd_en_i & ~empty_o;

  xclk_fifo_ptr #(.W(CW)) u_wptr (
    .clk_i(wclk_i), .rst_ni(wrst_n), .inc_i(wr_do), .bin_o(wbin), .gray_o(wgray));
  xclk_fifo_ptr #(.W(CW)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rrst_n), .inc_i(rd_do), .bin_o(rbin), .gray_o(rgray));

  xclk_fifo_sync #(.W(CW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_r));
  xclk_fifo_sync #(.W(CW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_w));

  xclk_fifo_g2b #(.W(CW)) u_wg2b (.gray_i(wgray_r), .bin_o(wbin_r));
  xclk_fifo_g2b #(.W(CW)) u_rg2b (.gray_i(rgray_w), .bin_o(rbin_w));

  // write side: full when pointers differ only in the two top Gray bits
  assign full_o        = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign wr_count_o    = wbin - rbin_w;
  assign almost_full_o = (wr_count_o >= CW'(AF_LEVEL));

  // read side
  assign empty_o        = (rgray == wgray_r);
  assign rd_count_o     = wbin_r - rbin;
  assign almost_empty_o = (rd_count_o <= CW'(AE_LEVEL));
  assign guard_o        = (rd_count_o > CW'(GUARD_LEVEL));

  always_ff @(posedge wclk_i) begin
    if (wr_do) mem[wbin[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge wclk_i or negedge wrst_n) begin
    if (!wrst_n)                overflow_o <= 1'b0;
    else if (wr_en_i && full_o) overflow_o <= 1'b1;
  end

  always_ff @(posedge rclk_i or negedge rrst_n) begin
    if (!rrst_n)                 underflow_o <= 1'b0;
    else if (rd_en_i && empty_o) underflow_o <= 1'b1;
  end

  if (IS_FWFT) begin : g_fwft
    assign rd_data_o  = mem[rbin[AW-1:0]];
    assign rd_valid_o = ~empty_o;
  end else begin : g_std
    logic [DATA_W-1:0] dat_q;
    logic              vld_q;
    always_ff @(posedge rclk_i or negedge rrst_n) begin
      if (!rrst_n) begin
        dat_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= rd_do;
        if (rd_do) dat_q <= mem[rbin[AW-1:0]];
      end
    end
    assign rd_data_o  = dat_q;
    assign rd_valid_o = vld_q;
  end
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int  DEPTH   = 16,
  parameter bit  IS_FWFT = 1'b1,
  localparam int CW      = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          overflow_o,
  input logic          underflow_o,
  input logic          rd_valid_o,
  input logic          guard_o,
  input logic [CW-1:0] wr_count_o,
  input logic [CW-1:0] rd_count_o
);
  a_r3_full_count: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> wr_count_o == CW'(DEPTH));
  a_r3_ovf_sticky: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r4_empty_count: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> rd_count_o == '0);
  a_r4_unf_sticky: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  a_r8_wr_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_count_o <= CW'(DEPTH));
  a_r8_rd_bound: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_count_o <= CW'(DEPTH));
  a_r10_guard_nonempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    guard_o |-> !empty_o);

  if (IS_FWFT) begin : g_fwft
    // head word stays presented until consumed
    a_r6_head_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      (rd_valid_o && !rd_en_i) |=> rd_valid_o);
  end else begin : g_std
    a_r5_std_valid: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      (rd_en_i && !empty_o) |=> rd_valid_o);
    a_r5_std_idle: assert property (@(posedge rclk_i) disable iff (!rst_ni)
      !(rd_en_i && !empty_o) |=> !rd_valid_o);
  end
endmodule

bind xclk_fifo xclk_fifo_chk #(.DEPTH(DEPTH), .IS_FWFT(IS_FWFT)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .full_o(full_o), .empty_o(empty_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o),
  .rd_valid_o(rd_valid_o), .guard_o(guard_o),
  .wr_count_o(wr_count_o), .rd_count_o(rd_count_o)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/100ps
module xclk_fifo_bench;
  import xclk_fifo_pkg::*;

  localparam int DW = 8, DEPTH = 16, AF = 12, AE = 2, GUARD = 5, CW = 5;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic full, afull, ovf, rvld, empty, aempty, guard, unf;
  logic [CW-1:0] wcnt, rcnt;
  logic [DW-1:0] rdat;
  logic full_s, afull_s, ovf_s, rvld_s, empty_s, aempty_s, guard_s, unf_s;
  logic [CW-1:0] wcnt_s, rcnt_s;
  logic [DW-1:0] rdat_s;

  always #2   wclk = ~wclk;  // 250 MHz writer
  always #1.7 rclk = ~rclk;  // faster reader

  xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AF_LEVEL(AF), .AE_LEVEL(AE),
              .GUARD_LEVEL(GUARD), .RD_MODE(RD_FWFT)) u_xclk_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full), .almost_full_o(afull),
    .wr_count_o(wcnt), .overflow_o(ovf),
    .rd_en_i(rd_en), .rd_data_o(rdat), .rd_valid_o(rvld), .empty_o(empty),
    .almost_empty_o(aempty), .guard_o(guard), .rd_count_o(rcnt), .underflow_o(unf));

  xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AF_LEVEL(AF), .AE_LEVEL(AE),
              .GUARD_LEVEL(GUARD), .RD_MODE(RD_STD)) u_xclk_fifo_std (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full_s), .almost_full_o(afull_s),
    .wr_count_o(wcnt_s), .overflow_o(ovf_s),
    .rd_en_i(rd_en), .rd_data_o(rdat_s), .rd_valid_o(rvld_s), .empty_o(empty_s),
    .almost_empty_o(aempty_s), .guard_o(guard_s), .rd_count_o(rcnt_s), .underflow_o(unf_s));

  int nvec = 0, nerr = 0;
  logic [DW-1:0] q[$];
  bit w_auto = 0, r_auto = 0, exp_ovf = 0, exp_unf = 0, pend = 0;
  int w_rate = 0, r_rate = 0, w_force_n = 0, r_force_n = 0;
  logic [DW-1:0] pend_d = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  // write domain: check, then drive
  initial begin
    forever begin
      bit en;
      logic [DW-1:0] d;
      @(negedge wclk);
      if (!rst_n) begin wr_en = 1'b0; continue; end
      chk(wcnt <= CW'(DEPTH), "R8 wr_count bound", int'(wcnt), DEPTH);
      chk(full == (wcnt == CW'(DEPTH)), "R3 full vs count", int'(full), int'(wcnt == CW'(DEPTH)));
      chk(afull == (wcnt >= CW'(AF)), "R9 almost_full", int'(afull), int'(wcnt >= CW'(AF)));
      chk(ovf == exp_ovf && ovf_s == exp_ovf, "R3 overflow", int'(ovf), int'(exp_ovf));
      chk(full_s == full && wcnt_s == wcnt, "R8 wr side match", int'(wcnt_s), int'(wcnt));
      en = 1'b0;
      if (w_force_n > 0) begin en = 1'b1; w_force_n--; end
      else if (w_auto) en = ($urandom % 100) < w_rate;
      d = DW'($urandom);
      if (en) begin
        if (full) exp_ovf = 1'b1;
        else      q.push_back(d);
      end
      wr_en   = en;
      wr_data = d;
    end
  end

  // read domain: check, then drive
  initial begin
    forever begin
      bit en;
      @(negedge rclk);
      if (!rst_n) begin rd_en = 1'b0; pend = 1'b0; continue; end
      chk(rvld == !empty, "R6 valid tracks not-empty", int'(rvld), int'(!empty));
      if (!empty) begin
        if (q.size() == 0) chk(1'b0, "R2 word without write", int'(rdat), -1);
        else               chk(rdat == q[0], "R2 R6 head word", int'(rdat), int'(q[0]));
      end
      chk(rvld_s == pend, "R5 std valid", int'(rvld_s), int'(pend));
      if (pend) chk(rdat_s == pend_d, "R2 R5 std data", int'(rdat_s), int'(pend_d));
      chk(empty_s == empty && rcnt_s == rcnt, "R8 rd side match", int'(rcnt_s), int'(rcnt));
      chk(empty == (rcnt == '0), "R4 empty vs count", int'(empty), int'(rcnt == '0));
      chk(aempty == (rcnt <= CW'(AE)), "R9 almost_empty", int'(aempty), int'(rcnt <= CW'(AE)));
      chk(guard == (rcnt > CW'(GUARD)) && guard_s == guard, "R10 guard", int'(guard),
          int'(rcnt > CW'(GUARD)));
      chk(unf == exp_unf && unf_s == exp_unf, "R4 underflow", int'(unf), int'(exp_unf));
      en = 1'b0;
      if (r_force_n > 0) begin en = 1'b1; r_force_n--; end
      else if (r_auto) en = ($urandom % 100) < r_rate;
      pend = 1'b0;
      if (en) begin
        if (empty) exp_unf = 1'b1;
        else begin pend = 1'b1; pend_d = q.pop_front(); end
      end
      rd_en = en;
    end
  end

  task automatic reset_state_check();
    chk(empty && empty_s, "R1 empty", int'(empty), 1);
    chk(!full && !full_s, "R1 full", int'(full), 0);
    chk(wcnt == '0 && rcnt == '0, "R1 counts", int'(wcnt), 0);
    chk(!ovf && !unf && !ovf_s && !unf_s, "R1 sticky flags", int'(ovf), 0);
    chk(!rvld && !rvld_s && !guard && !afull, "R1 valid/guard/afull", int'(rvld_s), 0);
    chk(aempty && aempty_s, "R1 almost_empty", int'(aempty), 1);
  endtask

  task automatic quiet_check(input string req);
    wait (w_force_n == 0 && r_force_n == 0);
    repeat (12) @(negedge wclk);
    chk(wcnt == CW'(q.size()), req, int'(wcnt), q.size());
    @(negedge rclk);
    chk(rcnt == CW'(q.size()), req, int'(rcnt), q.size());
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge wclk);
    reset_state_check();
    rst_n = 1'b1;
    repeat (6) @(negedge wclk);
    reset_state_check();

    // R7: single word crossing into an idle read side
    #1 w_force_n = 1;
    @(negedge wclk);
    @(posedge wclk);
    @(posedge rclk);
    @(negedge rclk);
    chk(empty && empty_s, "R7 still empty after one read edge", int'(empty), 1);
    repeat (4) @(negedge rclk);
    chk(!empty && !empty_s, "R7 visible after sync", int'(empty), 0);
    quiet_check("R8 idle counts (1 word)");

    // R10 boundary at 5 and 6 words
    w_force_n = 4;
    quiet_check("R8 idle counts (5 words)");
    chk(!guard && !guard_s, "R10 guard low at 5", int'(guard), 0);
    w_force_n = 1;
    quiet_check("R8 idle counts (6 words)");
    chk(guard && guard_s, "R10 guard high at 6", int'(guard), 1);

    // R3: write past full
    w_force_n = DEPTH + 3;
    quiet_check("R8 idle counts (full)");
    chk(full && full_s, "R3 full", int'(full), 1);
    chk(wcnt == CW'(DEPTH), "R3 count at full", int'(wcnt), DEPTH);
    chk(ovf && ovf_s, "R3 overflow set", int'(ovf), 1);
    chk(q.size() == DEPTH, "R3 ignored writes", q.size(), DEPTH);
    chk(afull && !aempty, "R9 flags at full", int'(afull), 1);

    // R4: read past empty
    r_force_n = DEPTH + 3;
    quiet_check("R8 idle counts (drained)");
    chk(empty && empty_s, "R4 empty", int'(empty), 1);
    chk(unf && unf_s, "R4 underflow set", int'(unf), 1);
    chk(aempty && !afull, "R9 flags at empty", int'(aempty), 1);

    // random phases: intermittent, filling, draining
    w_rate = 60; r_rate = 80; w_auto = 1; r_auto = 1;
    repeat (3000) @(negedge rclk);
    w_rate = 95; r_rate = 25;
    repeat (2000) @(negedge rclk);
    w_rate = 20; r_rate = 100;
    repeat (2000) @(negedge rclk);
    w_rate = 50; r_rate = 50;
    repeat (2000) @(negedge rclk);
    w_auto = 0; r_auto = 0;
    quiet_check("R8 idle counts (after random)");

    // R1: asynchronous reset in the middle of traffic
    w_rate = 70; r_rate = 60; w_auto = 1; r_auto = 1;
    repeat (500) @(negedge rclk);
    #0.7;
    rst_n = 1'b0;
    w_auto = 0; r_auto = 0;
    q.delete();
    exp_ovf = 1'b0; exp_unf = 1'b0;
    #5;
    reset_state_check();
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (6) @(negedge wclk);
    reset_state_check();
    quiet_check("R8 idle counts (after reset)");

    finish_run();
  end

  initial begin
    #800000;
    nvec++;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule